// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches page translations from virtual to physical addresses. It is direct-mapped: the slot for a virtual page number (VPN) is its low bits, and each slot holds three independent tags, one for each access kind (instruction fetch, data load, data store). All three tags in a slot share one data word, the page-number offset. A translation therefore answers only those access kinds that have actually refilled it. When a refill lands on a slot, any tag of another kind that belongs to a different page is dropped.

A requester presents a virtual address and an access kind on the lookup side. It gets back, in the same cycle, either a hit with the physical address or a miss. The block does not walk page tables, check permissions or fetch anything when a lookup misses. The requester resolves the miss elsewhere and writes the result back through the refill side. A flush input drops every tag at once.

Each clock edge applies one update kind, decoded from the control inputs:
- `UPD_IDLE`: nothing changes.
- `UPD_REFILL`: a refill without flush. The tag of the refill's kind is written. Tags of other kinds that name a different page are dropped. The data word is replaced.
- `UPD_FLUSH`: flush asserted, whether or not a refill is also present. Every tag is dropped.

The update kind comes straight from the inputs each cycle; it is not held from one cycle to the next. Reset puts the block in the same condition as a flush.

Top module: `split_tag_tlb`

## Requirements
- R1: The slot index is VPN modulo ENTRIES, which is the low 4 bits of the VPN at the defaults. The tag is the full VPN. A refill of a page evicts a page of the same kind that shares its slot but differs in a higher VPN bit.
- R2: Access kind codes are 0 = fetch, 1 = load and 2 = store. Code 3 behaves as load on both the lookup side and the refill side. A lookup hits only when the tag of its own kind at the slot equals the VPN.
- R3: On a hit, lk_paddr equals lk_vaddr plus the stored offset, modulo 2^ADDR_W. The stored offset is the refill's physical page base minus its virtual page base, so the result is {refilled physical page number, lk_vaddr[11:0]}.
- R4: A refill writes only the tag of its own kind. The same page looked up with another kind that was never refilled still misses.
- R5: A refill drops any other-kind tag in its slot that names a different page. An other-kind tag naming the same page is kept, and it then uses the newly written offset.
- R6: A flush drops every tag of every kind on the next edge. When flush and refill are asserted in the same cycle, flush wins and no tag is written.
- R7: Lookup is combinational. A refill or flush takes effect on the next rising edge, so a lookup in the same cycle sees the old contents.
- R8: After reset every lookup misses. The dropped-tag value is all ones over VPN width plus one bit, and it never matches any VPN, including the all-ones VPN.
- R9: On a miss, lk_paddr is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_vaddr | input | ADDR_W (32) | Lookup virtual address |
| lk_kind | input | 2 | Lookup access kind |
| lk_hit | output | 1 | Lookup hit |
| lk_paddr | output | ADDR_W (32) | Translated address on hit, zero on miss |
| fill_en | input | 1 | Refill strobe |
| fill_kind | input | 2 | Refill access kind |
| fill_vaddr | input | ADDR_W (32) | Refill virtual address |
| fill_paddr | input | ADDR_W (32) | Refill physical address |
| flush_all | input | 1 | Drop every tag |

## Verification
The bench builds the block with its defaults: 16 slots, 12-bit page offset and 32-bit addresses. The VPNs it draws come from a small pool that shares only three index values, so slot collisions, cross-kind eviction and same-page tag retention all occur often. The all-ones VPN lies within reach, as does wrap-around of the offset addition. Flush is made to coincide with refills on purpose.

// File: rtl/stt_pkg.sv
package stt_pkg;

    localparam logic [1:0] KIND_FETCH = 2'd0;
    localparam logic [1:0] KIND_LOAD  = 2'd1;
    localparam logic [1:0] KIND_STORE = 2'd2;
    localparam int unsigned NUM_KINDS = 3;

    typedef enum logic [1:0] {
        UPD_IDLE   = 2'd0,
        UPD_REFILL = 2'd1,
        UPD_FLUSH  = 2'd2
    } upd_e;

    // Code 3 is folded onto load (R2)
    function automatic logic [1:0] kind_norm(input logic [1:0] k);
        return (k == 2'd3) ? KIND_LOAD : k;
    endfunction

endpackage

// File: rtl/stt_update_ctrl.sv
module stt_update_ctrl
    import stt_pkg::*;
(
    input  logic                 fill_en,
    input  logic                 flush_all,
    input  logic [1:0]           fill_kind,
    output upd_e                 upd,
    output logic [NUM_KINDS-1:0] own_sel
);

    // Update kind decode: flush wins over refill (R6)
    always_comb begin
        if (flush_all) begin
            upd = UPD_FLUSH;
        end else if (fill_en) begin
            upd = UPD_REFILL;
        end else begin
            upd = UPD_IDLE;
        end
    end

    // Which tag bank the refill owns
    always_comb begin
        own_sel = '0;
        unique case (upd)
            UPD_REFILL: own_sel[kind_norm(fill_kind)] = 1'b1;
            UPD_FLUSH:  own_sel = '0;
            UPD_IDLE:   own_sel = '0;
            default:    own_sel = '0;
        endcase
    end

endmodule

// File: rtl/stt_tag_bank.sv
module stt_tag_bank
    import stt_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned TAG_W   = 21,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  upd_e             upd,
    input  logic             own,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag
);

    localparam logic [TAG_W-1:0] TAG_NONE = '1;

    logic [TAG_W-1:0] tags [ENTRIES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                tags[i] <= TAG_NONE;
            end
        end else begin
            unique case (upd)
                UPD_IDLE: begin
                end
                UPD_FLUSH: begin
                    for (int i = 0; i < ENTRIES; i++) begin
                        tags[i] <= TAG_NONE;
                    end
                end
                UPD_REFILL: begin
                    if (own) begin
                        tags[wr_idx] <= wr_tag;
                    end else if (tags[wr_idx] != wr_tag) begin
                        tags[wr_idx] <= TAG_NONE;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    assign rd_tag = tags[rd_idx];

endmodule

// File: rtl/stt_data_bank.sv
module stt_data_bank
    import stt_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned DATA_W  = 20,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  upd_e              upd,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [ENTRIES];

    always_ff @(posedge clk) begin
        if (upd == UPD_REFILL) begin
            words[wr_idx] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/split_tag_tlb.sv
module split_tag_tlb
    import stt_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned PG_BITS = 12,
    parameter int unsigned ADDR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_vaddr,
    input  logic [1:0]        lk_kind,
    output logic              lk_hit,
    output logic [ADDR_W-1:0] lk_paddr,
    input  logic              fill_en,
    input  logic [1:0]        fill_kind,
    input  logic [ADDR_W-1:0] fill_vaddr,
    input  logic [ADDR_W-1:0] fill_paddr,
    input  logic              flush_all
);

    localparam int unsigned VPN_W = ADDR_W - PG_BITS;
    localparam int unsigned IDX_W = $clog2(ENTRIES);
    localparam int unsigned TAG_W = VPN_W + 1;

    upd_e                 upd;
    logic [NUM_KINDS-1:0] own_sel;

    logic [VPN_W-1:0] lk_vpn, fill_vpn, fill_ppn;
    logic [IDX_W-1:0] lk_idx, fill_idx;
    logic [TAG_W-1:0] fill_tag, lk_tag;
    logic [TAG_W-1:0] rd_tags [NUM_KINDS];
    logic [VPN_W-1:0] rd_off;
    logic [TAG_W-1:0] sel_tag;

    assign lk_vpn   = lk_vaddr[ADDR_W-1:PG_BITS];
    assign fill_vpn = fill_vaddr[ADDR_W-1:PG_BITS];
    assign fill_ppn = fill_paddr[ADDR_W-1:PG_BITS];
    assign lk_idx   = lk_vpn[IDX_W-1:0];
    assign fill_idx = fill_vpn[IDX_W-1:0];
    assign fill_tag = {1'b0, fill_vpn};
    assign lk_tag   = {1'b0, lk_vpn};

    stt_update_ctrl u_ctrl (
        .fill_en   (fill_en),
        .flush_all (flush_all),
        .fill_kind (fill_kind),
        .upd       (upd),
        .own_sel   (own_sel)
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
        stt_tag_bank #(
            .ENTRIES (ENTRIES),
            .TAG_W   (TAG_W)
        ) u_tags (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd    (upd),
            .own    (own_sel[k]),
            .wr_idx (fill_idx),
            .wr_tag (fill_tag),
            .rd_idx (lk_idx),
            .rd_tag (rd_tags[k])
        );
    end

    stt_data_bank #(
        .ENTRIES (ENTRIES),
        .DATA_W  (VPN_W)
    ) u_data (
        .clk     (clk),
        .upd     (upd),
        .wr_idx  (fill_idx),
        .wr_data (fill_ppn - fill_vpn),
        .rd_idx  (lk_idx),
        .rd_data (rd_off)
    );

    always_comb begin
        unique case (kind_norm(lk_kind))
            KIND_FETCH: sel_tag = rd_tags[0];
            KIND_STORE: sel_tag = rd_tags[2];
            default:    sel_tag = rd_tags[1];
        endcase
    end

    always_comb begin
        lk_hit   = (sel_tag == lk_tag);
        lk_paddr = '0;
        if (lk_hit) begin
            lk_paddr = {lk_vpn + rd_off, lk_vaddr[PG_BITS-1:0]};
        end
    end

endmodule

// File: rtl/stt_checker.sv
module stt_checker
    import stt_pkg::*;
#(
    parameter int unsigned PG_BITS = 12,
    parameter int unsigned ADDR_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] lk_vaddr,
    input logic [1:0]        lk_kind,
    input logic              lk_hit,
    input logic [ADDR_W-1:0] lk_paddr,
    input logic              fill_en,
    input logic [1:0]        fill_kind,
    input logic [ADDR_W-1:0] fill_vaddr,
    input logic [ADDR_W-1:0] fill_paddr,
    input logic              flush_all
);

    // R6
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> !lk_hit);

    // R7
    fill_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !flush_all) |=>
            (!((lk_vaddr[ADDR_W-1:PG_BITS] == $past(fill_vaddr[ADDR_W-1:PG_BITS]))
               && (kind_norm(lk_kind) == kind_norm($past(fill_kind))))
             || (lk_hit && lk_paddr == {$past(fill_paddr[ADDR_W-1:PG_BITS]),
                                        lk_vaddr[PG_BITS-1:0]})));

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_paddr == '0);

    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> lk_paddr[PG_BITS-1:0] == lk_vaddr[PG_BITS-1:0]);

    // R8
    reset_empty_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !lk_hit);

endmodule

bind split_tag_tlb stt_checker #(
    .PG_BITS (PG_BITS),
    .ADDR_W  (ADDR_W)
) u_stt_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_vaddr   (lk_vaddr),
    .lk_kind    (lk_kind),
    .lk_hit     (lk_hit),
    .lk_paddr   (lk_paddr),
    .fill_en    (fill_en),
    .fill_kind  (fill_kind),
    .fill_vaddr (fill_vaddr),
    .fill_paddr (fill_paddr),
    .flush_all  (flush_all)
);

// File: tb/test_split_tag_tlb.sv
`timescale 1ns/1ps
module test_split_tag_tlb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_vaddr = '0;
    logic [1:0]  lk_kind = '0;
    logic        lk_hit;
    logic [31:0] lk_paddr;
    logic        fill_en = 1'b0;
    logic [1:0]  fill_kind = '0;
    logic [31:0] fill_vaddr = '0;
    logic [31:0] fill_paddr = '0;
    logic        flush_all = 1'b0;

    int checks = 0;
    int fails  = 0;

    // Bench-side picture of the cache
    logic [20:0] mtag [3][16];
    logic [19:0] moff [16];

    always #2 clk = ~clk;

    split_tag_tlb i_split_tag_tlb (
        .clk, .rst_n, .lk_vaddr, .lk_kind, .lk_hit, .lk_paddr,
        .fill_en, .fill_kind, .fill_vaddr, .fill_paddr, .flush_all
    );

    function automatic int nk(input logic [1:0] k);
        return (k == 2'd3) ? 1 : int'(k);
    endfunction

    function automatic logic exp_hit(input logic [31:0] va, input logic [1:0] k);
        return mtag[nk(k)][va[15:12]] == {1'b0, va[31:12]};
    endfunction

    function automatic logic [31:0] exp_pa(input logic [31:0] va, input logic [1:0] k);
        if (!exp_hit(va, k)) return 32'd0;
        return {va[31:12] + moff[va[15:12]], va[11:0]};
    endfunction

    task automatic model_clear();
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < 16; i++) mtag[t][i] = '1;
    endtask

    task automatic model_edge(input logic fe, input logic [1:0] fk,
                              input logic [31:0] fva, input logic [31:0] fpa,
                              input logic fl);
        if (fl) begin
            model_clear();
        end else if (fe) begin
            for (int t = 0; t < 3; t++) begin
                if (t == nk(fk)) mtag[t][fva[15:12]] = {1'b0, fva[31:12]};
                else if (mtag[t][fva[15:12]] != {1'b0, fva[31:12]})
                    mtag[t][fva[15:12]] = '1;
            end
            moff[fva[15:12]] = fpa[31:12] - fva[31:12];
        end
    endtask

    // Entered at a falling edge, returns at the next falling edge
    task automatic step(input string tag, input logic fe, input logic [1:0] fk,
                        input logic [31:0] fva, input logic [31:0] fpa,
                        input logic fl, input logic [31:0] lva,
                        input logic [1:0] lk);
        logic eh;
        logic [31:0] ep;
        fill_en = fe; fill_kind = fk; fill_vaddr = fva; fill_paddr = fpa;
        flush_all = fl; lk_vaddr = lva; lk_kind = lk;
        #1;
        eh = exp_hit(lva, lk);
        ep = exp_pa(lva, lk);
        checks++;
        if (lk_hit !== eh || lk_paddr !== ep) begin
            fails++;
            $display("FAIL %s va=%h kind=%0d hit=%b exp=%b paddr=%h exp=%h",
                     tag, lva, lk, lk_hit, eh, lk_paddr, ep);
        end
        @(posedge clk);
        model_edge(fe, fk, fva, fpa, fl);
        @(negedge clk);
    endtask

    task automatic look(input string tag, input logic [31:0] va, input logic [1:0] k);
        step(tag, 1'b0, 2'd0, 32'd0, 32'd0, 1'b0, va, k);
    endtask

    function automatic logic [31:0] pick_va();
        logic [19:0] vpn;
        logic [3:0]  lo [3] = '{4'h5, 4'hA, 4'hF};
        if ($urandom % 16 == 0) vpn = 20'hFFFFF;
        else vpn = {4'h0, 12'(($urandom % 4) * 32'h111), lo[$urandom % 3]};
        return {vpn, 12'($urandom)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        model_clear();
        for (int i = 0; i < 16; i++) moff[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R8 R9: empty after reset, all kinds, including all-ones page
        for (int k = 0; k < 4; k++) look("R8", 32'h0000_0000, 2'(k));
        look("R8_all_ones", 32'hFFFF_F123, 2'd0);

        // R7: same-cycle lookup sees old contents
        step("R7", 1'b1, 2'd0, 32'h1234_5ABC, 32'h9876_5000, 1'b0, 32'h1234_5010, 2'd0);
        // R3: hit with translated address
        look("R3", 32'h1234_5010, 2'd0);
        // R4: load never refilled for this page
        look("R4", 32'h1234_5010, 2'd1);
        // R5: same-page load refill keeps fetch tag, new shared offset
        step("R5_keep", 1'b1, 2'd1, 32'h1234_5000, 32'h1111_1000, 1'b0, 32'h1234_5FFF, 2'd0);
        look("R5_shared", 32'h1234_5FFF, 2'd0);
        look("R2_load", 32'h1234_5004, 2'd1);
        // R2: kind 3 behaves as load
        look("R2_code3", 32'h1234_5004, 2'd3);
        // R1 R5: other page, same slot, store kind drops fetch and load
        step("R1", 1'b1, 2'd2, 32'h0004_5000, 32'h0777_7000, 1'b0, 32'h0004_5000, 2'd2);
        look("R5_drop_fetch", 32'h1234_5010, 2'd0);
        look("R5_drop_load", 32'h1234_5010, 2'd1);
        look("R1_store", 32'h0004_5008, 2'd2);
        // R2: refill with code 3 fills load
        step("R2_fill3", 1'b1, 2'd3, 32'h0004_5000, 32'h0777_7000, 1'b0, 32'h0004_5000, 2'd1);
        look("R2_fill3_hit", 32'h0004_5ABC, 2'd1);
        look("R2_fill3_store", 32'h0004_5ABC, 2'd2);
        // R6: flush with refill in the same cycle
        step("R6", 1'b1, 2'd0, 32'hABCD_E000, 32'h0000_1000, 1'b1, 32'h0004_5000, 2'd1);
        look("R6_fill_lost", 32'hABCD_E000, 2'd0);
        look("R6_flushed", 32'h0004_5000, 2'd2);
        // R8 R3: all-ones page, offset wrap
        look("R8_all_ones_flushed", 32'hFFFF_F000, 2'd1);
        step("R3_wrap", 1'b1, 2'd1, 32'hFFFF_F000, 32'h0000_2000, 1'b0, 32'h0, 2'd1);
        look("R3_wrap_hit", 32'hFFFF_F345, 2'd1);

        // Random mix of refills, flushes and lookups (R1..R9)
        for (int n = 0; n < 4000; n++) begin
            logic fe, fl;
            logic [31:0] fva;
            fe  = ($urandom % 3) != 0;
            fl  = ($urandom % 40) == 0;
            fva = ($urandom % 2) ? pick_va() : 32'h0;
            if (fva == 32'h0) fva = pick_va();
            step("R_random", fe, 2'($urandom), fva, $urandom, fl,
                 pick_va(), 2'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule